// File: doc/BRIEF.md
# Instruction Fetch Frontend with Stage-Prioritised Redirect

This block is the fetch end of a processor pipeline. It holds the program counter, issues word-aligned read commands on a simple instruction bus (a valid/ready command channel, then an in-order response channel that carries valid, data and an error flag) and hands each fetched word, with the address it came from, to the decode side through a valid/ready output. A small output buffer absorbs decode back-pressure. A new command is issued only when every outstanding fetch is sure to find room in that buffer.

Any pipeline stage may ask for a redirect by raising its own request line with a target address. When several stages ask in the same cycle, the stage with the highest index, which is the one furthest down the pipeline, wins. A redirect flushes the output buffer. It also marks every fetch still in flight as stale, and the responses to those fetches are later discarded. Three compile-time switches change the behaviour. The first chooses whether the redirect target reaches the bus address combinationally or one cycle later. The second chooses whether a presented command is held until the bus accepts it. The third chooses whether bus errors become access-fault entries.

Top module: `fetch_frontend`

## Requirements
- R1: After reset the output is empty, and the first command address is the reset-vector parameter unless a redirect arrives first.
- R2: Without a redirect, each accepted command address is the previous accepted address plus 4. Command addresses always have bits [1:0] equal to 0.
- R3: With the combinational redirect option (REG_JUMP=0), in a cycle with a redirect request and no held command, a presented command carries the winning target in that same cycle.
- R4: With the registered redirect option (REG_JUMP=1), no new command is presented in the cycle a redirect is requested. The next accepted fresh command carries the target, which is one cycle later than in R3.
- R5: With persistence (PERSIST=1), a command that is presented and not accepted is presented again in the next cycle with the same address, even across a redirect. Once it is accepted, fetching continues at the redirect target.
- R6: Among simultaneous redirect requests, the request on the highest-numbered stage line selects the target.
- R7: A response to a command issued before a later redirect, or a response that arrives in a redirect cycle, never reaches the output.
- R8: A redirect empties the output buffer at the next clock edge. An output handshake in the redirect cycle does not count.
- R9: With CATCH_FAULT=1, a response with the error flag set yields an output entry with outFault=1, outInstr=0 and the fetch address.
- R10: With CATCH_FAULT=0, the error flag is ignored: outFault stays 0 and outInstr is the response data.
- R11: Commands in flight plus buffered output entries never exceed DEPTH.
- R12: Fresh responses leave the output in issue order with their fetch address. An entry that is refused holds steady while no redirect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| jumpValid | input | NUM_STAGES | Redirect request, one line per stage; the highest index wins |
| jumpTarget | input | NUM_STAGES*ADDR_W | Redirect targets, stage i in slice i |
| cmdValid | output | 1 | Command presented |
| cmdReady | input | 1 | Bus accepts the command |
| cmdAddr | output | ADDR_W | Fetch address |
| rspValid | input | 1 | Response present, in command order |
| rspData | input | DATA_W | Fetched word |
| rspError | input | 1 | Bus error for this fetch |
| outValid | output | 1 | Output entry available |
| outReady | input | 1 | Decode takes the entry |
| outPc | output | ADDR_W | Address of the entry |
| outInstr | output | DATA_W | Instruction word (0 on fault) |
| outFault | output | 1 | Access fault on this fetch |

## Verification
The bench builds two copies side by side. The first uses the combinational redirect with persistent commands and fault capture. The second uses the registered redirect with withdrawable commands and errors ignored. Between them, the same-cycle and the one-cycle-late redirect paths, the held command that becomes stale when a redirect lands during its hold, a command that is withdrawn in a redirect cycle, and both treatments of bus errors can all be reached. Random bus latency, ready stalls and decode stalls keep the output buffer and the credit limit busy, while bursts of multi-stage redirects exercise the priority order and the dropping of stale responses.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef struct packed {
    logic cmdFire;    // command accepted this cycle
    logic jumpNow;    // a redirect request is present
    logic jumpComb;   // target drives the bus address directly
    logic held;       // presented command is being held
    logic staleFire;  // held command accepted after a redirect
    logic rspTake;    // a response retires an address entry
    logic rspPush;    // a fresh response enters the output buffer
    logic outPop;     // decode takes the head entry
    logic flush;      // empty the output buffer
  } fetchStrobes_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int NUM_STAGES = 3,
  parameter int DEPTH = 4,
  parameter bit REG_JUMP = 1'b0,
  parameter bit PERSIST = 1'b1,
  localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_STAGES-1:0] jumpValid,
  input  logic                  cmdReady,
  input  logic                  rspValid,
  input  logic                  outReady,
  output logic                  cmdValid,
  output logic                  outValid,
  output logic [IDX_W-1:0]      jumpIdx,
  output fetchStrobes_t         strb
);
  logic heldQ, pendQ;
  logic [CNT_W-1:0] inflightQ, dropQ, outCntQ;
  logic canIssue, dropRsp;

  // later stage overrides earlier
  always_comb begin
    jumpIdx = '0;
    for (int i = 0; i < NUM_STAGES; i++)
      if (jumpValid[i]) jumpIdx = IDX_W'(i);
  end

  assign canIssue = ({1'b0, inflightQ} + {1'b0, outCntQ}) < (CNT_W+1)'(DEPTH);
  assign cmdValid = heldQ || (canIssue && !(REG_JUMP && strb.jumpNow));
  assign outValid = outCntQ != '0;
  assign dropRsp  = rspValid && (dropQ != '0 || strb.jumpNow);

  always_comb begin
    strb.jumpNow   = |jumpValid;
    strb.held      = heldQ;
    strb.cmdFire   = cmdValid && cmdReady;
    strb.jumpComb  = !REG_JUMP && strb.jumpNow && !heldQ;
    strb.staleFire = strb.cmdFire && heldQ && (strb.jumpNow || pendQ);
    strb.rspTake   = rspValid;
    strb.rspPush   = rspValid && !dropRsp;
    strb.outPop    = outValid && outReady && !strb.jumpNow;
    strb.flush     = strb.jumpNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ     <= 1'b0;
      pendQ     <= 1'b0;
      inflightQ <= '0;
      dropQ     <= '0;
      outCntQ   <= '0;
    end else begin
      heldQ <= PERSIST && cmdValid && !cmdReady;
      if (strb.cmdFire) pendQ <= 1'b0;
      else if (heldQ && strb.jumpNow) pendQ <= 1'b1;
      inflightQ <= inflightQ + CNT_W'(strb.cmdFire) - CNT_W'(rspValid);
      if (strb.jumpNow)
        dropQ <= inflightQ - CNT_W'(rspValid) + CNT_W'(strb.staleFire);
      else
        dropQ <= dropQ - CNT_W'(rspValid && dropQ != '0) + CNT_W'(strb.staleFire);
      if (strb.flush) outCntQ <= '0;
      else outCntQ <= outCntQ + CNT_W'(strb.rspPush) - CNT_W'(strb.outPop);
    end
  end
endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_STAGES = 3,
  parameter int DEPTH = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000,
  parameter bit CATCH_FAULT = 1'b1,
  localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fetchStrobes_t                strb,
  input  logic [IDX_W-1:0]             jumpIdx,
  input  logic [NUM_STAGES*ADDR_W-1:0] jumpTarget,
  input  logic [DATA_W-1:0]            rspData,
  input  logic                         rspError,
  output logic [ADDR_W-1:0]            cmdAddr,
  output logic [ADDR_W-1:0]            outPc,
  output logic [DATA_W-1:0]            outInstr,
  output logic                         outFault
);
  logic [ADDR_W-1:0] pcQ, pendTgtQ, tgt;
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [PTR_W-1:0]  aWr, aRd, oWr, oRd;
  logic [ADDR_W-1:0] oPcMem [DEPTH];
  logic [DATA_W-1:0] oInsMem [DEPTH];
  logic [DEPTH-1:0]  oFltMem;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign tgt     = {jumpTarget[jumpIdx*ADDR_W +: ADDR_W] >> 2, 2'b00};
  assign cmdAddr = strb.jumpComb ? tgt : pcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ      <= RESET_VEC;
      pendTgtQ <= RESET_VEC;
    end else begin
      if (strb.jumpNow) pendTgtQ <= tgt;
      if (strb.staleFire)       pcQ <= strb.jumpNow ? tgt : pendTgtQ;
      else if (strb.cmdFire)    pcQ <= cmdAddr + ADDR_W'(4);
      else if (!strb.held && strb.jumpNow) pcQ <= tgt;
    end
  end

  // address of every fetch in flight, retired in order
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aWr <= '0;
      aRd <= '0;
    end else begin
      if (strb.cmdFire) aWr <= nextPtr(aWr);
      if (strb.rspTake) aRd <= nextPtr(aRd);
    end
  end

  always_ff @(posedge clk)
    if (strb.cmdFire) addrMem[aWr] <= cmdAddr;

  // output buffer
  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      oWr <= '0;
      oRd <= '0;
    end else begin
      if (strb.rspPush) oWr <= nextPtr(oWr);
      if (strb.outPop)  oRd <= nextPtr(oRd);
    end
  end

  always_ff @(posedge clk)
    if (strb.rspPush) begin
      oPcMem[oWr]  <= addrMem[aRd];
      oInsMem[oWr] <= (CATCH_FAULT && rspError) ? '0 : rspData;
      oFltMem[oWr] <= CATCH_FAULT && rspError;
    end

  assign outPc    = oPcMem[oRd];
  assign outInstr = oInsMem[oRd];
  assign outFault = oFltMem[oRd];
endmodule

// File: rtl/fetch_frontend.sv
module fetch_frontend
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_STAGES = 3,
  parameter int DEPTH = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000,
  parameter bit REG_JUMP = 1'b0,
  parameter bit PERSIST = 1'b1,
  parameter bit CATCH_FAULT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_STAGES-1:0]        jumpValid,
  input  logic [NUM_STAGES*ADDR_W-1:0] jumpTarget,
  output logic                         cmdValid,
  input  logic                         cmdReady,
  output logic [ADDR_W-1:0]            cmdAddr,
  input  logic                         rspValid,
  input  logic [DATA_W-1:0]            rspData,
  input  logic                         rspError,
  output logic                         outValid,
  input  logic                         outReady,
  output logic [ADDR_W-1:0]            outPc,
  output logic [DATA_W-1:0]            outInstr,
  output logic                         outFault
);
  localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

  fetchStrobes_t strb;
  logic [IDX_W-1:0] jumpIdx;

  fetch_ctrl #(
    .NUM_STAGES(NUM_STAGES), .DEPTH(DEPTH),
    .REG_JUMP(REG_JUMP), .PERSIST(PERSIST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .jumpValid(jumpValid), .cmdReady(cmdReady),
    .rspValid(rspValid), .outReady(outReady), .cmdValid(cmdValid),
    .outValid(outValid), .jumpIdx(jumpIdx), .strb(strb)
  );

  fetch_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_STAGES(NUM_STAGES), .DEPTH(DEPTH),
    .RESET_VEC(RESET_VEC), .CATCH_FAULT(CATCH_FAULT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .jumpIdx(jumpIdx),
    .jumpTarget(jumpTarget), .rspData(rspData), .rspError(rspError),
    .cmdAddr(cmdAddr), .outPc(outPc), .outInstr(outInstr), .outFault(outFault)
  );
endmodule

// File: rtl/fetch_frontend_chk.sv
module fetch_frontend_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_STAGES = 3,
  parameter int DEPTH = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h1000,
  parameter bit REG_JUMP = 1'b0,
  parameter bit PERSIST = 1'b1,
  parameter bit CATCH_FAULT = 1'b1
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_STAGES-1:0]        jumpValid,
  input logic [NUM_STAGES*ADDR_W-1:0] jumpTarget,
  input logic                         cmdValid,
  input logic                         cmdReady,
  input logic [ADDR_W-1:0]            cmdAddr,
  input logic                         rspValid,
  input logic                         outValid,
  input logic                         outReady,
  input logic [ADDR_W-1:0]            outPc,
  input logic [DATA_W-1:0]            outInstr,
  input logic                         outFault
);
  logic [ADDR_W-1:0] selTgt;
  logic heldChk, startedChk;
  int inflightChk;

  always_comb begin
    selTgt = '0;
    for (int i = 0; i < NUM_STAGES; i++)
      if (jumpValid[i]) selTgt = {jumpTarget[i*ADDR_W+2 +: ADDR_W-2], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldChk     <= 1'b0;
      startedChk  <= 1'b0;
      inflightChk <= 0;
    end else begin
      heldChk <= PERSIST && cmdValid && !cmdReady;
      if ((cmdValid && cmdReady) || (|jumpValid)) startedChk <= 1'b1;
      inflightChk <= inflightChk + int'(cmdValid && cmdReady) - int'(rspValid);
    end
  end

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (!startedChk && cmdValid && !(|jumpValid)) |-> cmdAddr == RESET_VEC); // R1
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdAddr[1:0] == 2'b00); // R2
  AST_COMB_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (!REG_JUMP && (|jumpValid) && cmdValid && !heldChk) |-> cmdAddr == selTgt); // R3
  AST_REG_WITHDRAW: assert property (@(posedge clk) disable iff (!rstN)
    (REG_JUMP && !PERSIST && (|jumpValid)) |-> !cmdValid); // R4
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (PERSIST && cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdAddr))); // R5
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFault) |-> outInstr == '0); // R9
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!CATCH_FAULT && outValid) |-> !outFault); // R10
  AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    inflightChk <= DEPTH); // R11
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !(|jumpValid)) |=>
      (outValid && $stable(outPc) && $stable(outInstr))); // R12
endmodule

bind fetch_frontend fetch_frontend_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_STAGES(NUM_STAGES), .DEPTH(DEPTH),
  .RESET_VEC(RESET_VEC), .REG_JUMP(REG_JUMP), .PERSIST(PERSIST),
  .CATCH_FAULT(CATCH_FAULT)
) u_chk (
  .clk(clk), .rstN(rstN), .jumpValid(jumpValid), .jumpTarget(jumpTarget),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
  .rspValid(rspValid), .outValid(outValid), .outReady(outReady),
  .outPc(outPc), .outInstr(outInstr), .outFault(outFault)
);

// File: tb/fetch_frontend_test.sv
module fetch_frontend_harness #(
  parameter bit REG_JUMP = 1'b0,
  parameter bit PERSIST = 1'b1,
  parameter bit CATCH_FAULT = 1'b1,
  parameter int CYCLES = 4000
) (
  input  logic clk,
  input  logic rstN,
  output int   checks,
  output int   fails,
  output logic done
);
  localparam int NS = 3;
  localparam int DEPTH = 4;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic [NS-1:0]    jumpValid;
  logic [NS*32-1:0] jumpTarget;
  logic cmdValid, cmdReady, rspValid, rspError, outValid, outReady, outFault;
  logic [31:0] cmdAddr, rspData, outPc, outInstr;

  fetch_frontend #(
    .NUM_STAGES(NS), .DEPTH(DEPTH), .RESET_VEC(RVEC), .REG_JUMP(REG_JUMP),
    .PERSIST(PERSIST), .CATCH_FAULT(CATCH_FAULT)
  ) uut (
    .clk(clk), .rstN(rstN), .jumpValid(jumpValid), .jumpTarget(jumpTarget),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
    .rspValid(rspValid), .rspData(rspData), .rspError(rspError),
    .outValid(outValid), .outReady(outReady), .outPc(outPc),
    .outInstr(outInstr), .outFault(outFault)
  );

  typedef struct { logic [31:0] addr; bit stale; int due; } busEnt_t;
  typedef struct { logic [31:0] pc; logic [31:0] ins; bit flt; bit err; } outEnt_t;
  busEnt_t busQ[$];
  outEnt_t expQ[$];

  function automatic logic [31:0] dataOf(input logic [31:0] a);
    return ~a ^ 32'h1357_9BDF;
  endfunction
  function automatic bit errOf(input logic [31:0] a);
    return a[5:2] == 4'hB;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (cfg reg=%0d persist=%0d): actual %h expected %h",
               req, REG_JUMP, PERSIST, act, exp);
    end
  endtask

  initial begin
    logic [31:0] expNext, pendTgt, prevAddr, tgt;
    bit pendB, prevValid, prevReady, heldB, jumpAny, fire, stale, anyFire;
    int cyc, drops, redirects, errSeen;
    checks = 0; fails = 0; done = 1'b0;
    jumpValid = '0; jumpTarget = '0; cmdReady = 1'b0; rspValid = 1'b0;
    rspData = '0; rspError = 1'b0; outReady = 1'b0;
    expNext = RVEC; pendTgt = '0; pendB = 0; prevValid = 0; prevReady = 0;
    prevAddr = '0; anyFire = 0; cyc = 0; drops = 0; redirects = 0; errSeen = 0;
    @(negedge clk);
    #1 check(outValid == 1'b0, "R1 empty in reset", 32'(outValid), 0);
    wait (rstN);
    for (int n = 0; n < CYCLES; n++) begin
      @(negedge clk);
      // drive this cycle's inputs
      jumpValid = '0;
      if (($urandom % ((n < CYCLES / 3) ? 25 : 6)) == 0 && n > 3)
        jumpValid = NS'(1 + $urandom % ((1 << NS) - 1));
      for (int s = 0; s < NS; s++)
        jumpTarget[s*32 +: 32] = 32'h0000_2000 + 32'(($urandom % 512) * 4);
      cmdReady = ($urandom % 4) != 0;
      outReady = ($urandom % 3) != 0;
      rspValid = busQ.size() > 0 && busQ[0].due <= cyc;
      rspData  = rspValid ? dataOf(busQ[0].addr) : 32'hDEAD_BEEF;
      rspError = rspValid ? errOf(busQ[0].addr) : 1'b0;
      #1;
      jumpAny = |jumpValid;
      tgt = '0;
      for (int s = 0; s < NS; s++) if (jumpValid[s]) tgt = jumpTarget[s*32 +: 32];
      heldB = PERSIST && prevValid && !prevReady;
      fire = cmdValid && cmdReady;
      // output side, compared against the model before this edge
      check(outValid == (expQ.size() != 0), "R7/R8 output occupancy",
            32'(outValid), 32'(expQ.size() != 0));
      if (outValid && expQ.size() != 0) begin
        check(outPc == expQ[0].pc, "R12 entry address", outPc, expQ[0].pc);
        check(outFault == expQ[0].flt, expQ[0].err ? (CATCH_FAULT ? "R9 fault flag" : "R10 fault flag") : "R12 fault flag",
              32'(outFault), 32'(expQ[0].flt));
        check(outInstr == expQ[0].ins, expQ[0].err ? (CATCH_FAULT ? "R9 zero word" : "R10 data kept") : "R12 word",
              outInstr, expQ[0].ins);
        if (outReady && !jumpAny) void'(expQ.pop_front());
      end
      // command side
      if (heldB) begin
        check(cmdValid == 1'b1, "R5 held valid", 32'(cmdValid), 1);
        check(cmdAddr == prevAddr, "R5 held address", cmdAddr, prevAddr);
      end
      if (REG_JUMP && jumpAny && !heldB)
        check(cmdValid == 1'b0, "R4 no issue on redirect cycle", 32'(cmdValid), 0);
      if (fire && !heldB) begin
        if (jumpAny && !REG_JUMP)
          check(cmdAddr == tgt, "R3/R6 same-cycle redirect", cmdAddr, tgt);
        else
          check(cmdAddr == expNext, anyFire ? "R2/R4/R6 fetch address" : "R1 reset vector",
                cmdAddr, expNext);
      end
      stale = fire && heldB && (jumpAny || pendB);
      if (stale) begin
        expNext = jumpAny ? tgt : pendTgt;
        pendB = 0;
      end else if (fire) expNext = cmdAddr + 32'd4;
      else if (jumpAny) begin
        if (heldB) begin pendB = 1; pendTgt = tgt; end
        else expNext = tgt;
      end
      if (fire) anyFire = 1;
      // response side
      if (rspValid) begin
        busEnt_t e;
        e = busQ.pop_front();
        if (e.stale || jumpAny) drops++;
        else begin
          outEnt_t o;
          o.pc = e.addr;
          o.err = errOf(e.addr);
          if (o.err) errSeen++;
          o.flt = CATCH_FAULT && o.err;
          o.ins = o.flt ? 32'h0 : dataOf(e.addr);
          expQ.push_back(o);
        end
      end
      if (jumpAny) begin
        redirects++;
        foreach (busQ[k]) busQ[k].stale = 1;
        expQ.delete();
      end
      if (fire) begin
        busEnt_t b;
        b.addr = cmdAddr;
        b.stale = stale;
        b.due = cyc + 1 + int'($urandom % 4);
        if (busQ.size() > 0 && busQ[$].due > b.due) b.due = busQ[$].due;
        busQ.push_back(b);
      end
      check(busQ.size() + expQ.size() <= DEPTH, "R11 credit limit",
            32'(busQ.size() + expQ.size()), DEPTH);
      prevValid = cmdValid; prevReady = cmdReady; prevAddr = cmdAddr;
      cyc++;
    end
    check(drops > 0, "R7 stale responses dropped", 32'(drops), 1);
    check(redirects > 0, "R6 redirects seen", 32'(redirects), 1);
    check(errSeen > 0, CATCH_FAULT ? "R9 faults seen" : "R10 errors seen", 32'(errSeen), 1);
    done = 1'b1;
  end
endmodule

module fetch_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int chkA, failA, chkB, failB;
  logic doneA, doneB;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // combinational redirect, held commands, faults captured
  fetch_frontend_harness #(.REG_JUMP(1'b0), .PERSIST(1'b1), .CATCH_FAULT(1'b1)) hA (
    .clk(clk), .rstN(rstN), .checks(chkA), .fails(failA), .done(doneA));
  // registered redirect, withdrawable commands, errors ignored
  fetch_frontend_harness #(.REG_JUMP(1'b1), .PERSIST(1'b0), .CATCH_FAULT(1'b0)) hB (
    .clk(clk), .rstN(rstN), .checks(chkB), .fails(failB), .done(doneB));

  initial begin
    int waited;
    int extra;
    extra = 0;
    waited = 0;
    repeat (5) @(posedge clk);
    rstN = 1'b1;
    while (!(doneA === 1'b1 && doneB === 1'b1) && waited < WATCHDOG) begin
      @(posedge clk);
      waited++;
    end
    if (waited >= WATCHDOG) begin
      extra = 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", waited, WATCHDOG);
    end
    $display("[TB] %0d tests run, %0d failed", chkA + chkB + extra, failA + failB + extra);
    $finish;
  end
endmodule